// File: doc/BRIEF.md
# Block-Linear Tiled Address Generator

This block turns a pixel coordinate on a 32-bit-per-pixel surface into the byte offset of that pixel inside a framebuffer stored in block-linear tiles. A tile is one 64-byte group wide, which is 16 pixels at 4 bytes each. Its height is 8 pixel rows scaled up by a power of two taken from a 4-bit height exponent. Tiles are laid out row after row. Inside a tile, the position comes from a fixed interleave of the low x and y bits.

When the exponent is zero the surface is linear. The offset is then the row times the byte pitch, plus the column times the bytes per pixel.

Requests use a valid/ready handshake. The offset and an error flag come back one cycle after a request is accepted, on a response channel that also has valid/ready flow control. The block rejects these requests:
- requests that flag a compressed or multi-plane surface;
- coordinates that fall outside the surface;
- exponents that are too large;
- tiled requests whose pixel size is not 4 bytes.

Top module: `bl_addr_gen`

## Requirements
- R1: With blk_exp = 0 the offset is req_y × lin_pitch + req_x × bytes_pp, for any bytes_pp.
- R2: In tiled mode the tile base is ((req_y >> (3+blk_exp)) × ceil(surf_width/16) + (req_x >> 4)) × (512 << blk_exp). A width that is not a multiple of 16 rounds the row of tiles up.
- R3: The in-tile index has these bits, from bit 0 upward: x0, x1, y0, y1, x2, y2, x3, then the in-tile y bits from y3 up, starting at bit 7. The offset is the tile base plus 4 × index.
- R4: The tile height is 8 << blk_exp rows. Any blk_exp from 1 to 5 selects tiled addressing.
- R5: A tiled request (blk_exp ≠ 0) with bytes_pp ≠ 4 returns rsp_err = 1 and rsp_offset = 0.
- R6: A request with fmt_unsupp = 1 returns rsp_err = 1 and rsp_offset = 0.
- R7: req_x ≥ surf_width or req_y ≥ surf_height returns rsp_err = 1 and rsp_offset = 0.
- R8: blk_exp greater than 5 returns rsp_err = 1 and rsp_offset = 0.
- R9: rsp_valid rises on the clock edge after the edge that accepts a request (req_valid and req_ready both high).
- R10: While rsp_valid = 1 and rsp_ready = 0, req_ready is low and rsp_offset and rsp_err hold. req_ready is high whenever rsp_valid is low.
- R11: Reset (rst high, synchronous) clears rsp_valid and leaves req_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_x | input | 16 | Pixel column |
| req_y | input | 16 | Pixel row |
| surf_width | input | 16 | Surface width in pixels |
| surf_height | input | 16 | Surface height in pixels |
| blk_exp | input | 4 | Tile height exponent; 0 selects linear |
| bytes_pp | input | 3 | Bytes per pixel |
| lin_pitch | input | 18 | Linear row pitch in bytes |
| fmt_unsupp | input | 1 | Compressed or multi-plane surface |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_offset | output | 32 | Byte offset, zero on error |
| rsp_err | output | 1 | Request rejected |

## Verification
Every result is due one clock edge after the edge that accepts its request. The bench drives inputs on the falling edge, lets one rising edge pass, and reads rsp_valid, rsp_offset and rsp_err on the next falling edge. Under backpressure, the same result must still be present several edges later. The queued request must then appear on the edge that drains the held result, and the bench checks it one falling edge after that.

// File: rtl/bl_pkg.sv
package bl_pkg;
    localparam int COORD_W     = 16;
    localparam int PITCH_W     = 18;
    localparam int OFF_W       = 32;
    localparam int EXP_W       = 4;
    localparam int BPP_W       = 3;
    localparam int MAX_EXP     = 5;
    localparam int GOB_LOG2    = 6;   // 64-byte group
    localparam int PIX_LOG2    = 2;   // 4 bytes per pixel in tiled mode
    localparam int TILE_W_LOG2 = GOB_LOG2 - PIX_LOG2;
    localparam int BASE_H_LOG2 = 3;   // 8 rows at exponent 0
    localparam int YL_W        = BASE_H_LOG2 + MAX_EXP;
    localparam int SWZ_W       = 7 + MAX_EXP;

    typedef enum logic [2:0] {
        FLT_NONE,
        FLT_FORMAT,
        FLT_EXPONENT,
        FLT_DEPTH,
        FLT_RANGE
    } fault_e;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] width;
        logic [COORD_W-1:0] height;
        logic [EXP_W-1:0]   exp;
        logic [BPP_W-1:0]   bpp;
        logic [PITCH_W-1:0] pitch;
        logic               unsupp;
    } req_t;

    typedef struct packed {
        logic [OFF_W-1:0] offset;
        logic             err;
    } rsp_t;

    function automatic logic is_tiled(input logic [EXP_W-1:0] e);
        return e != '0;
    endfunction
endpackage

// File: rtl/bl_swizzle.sv
module bl_swizzle
    import bl_pkg::*;
#(
    parameter int YLW  = YL_W,
    parameter int SWW  = SWZ_W,
    parameter int EW   = EXP_W,
    parameter int MEXP = MAX_EXP
) (
    input  logic [3:0]     x_low,
    input  logic [YLW-1:0] y_low,
    input  logic [EW-1:0]  exp,
    output logic [SWW-1:0] swz
);
    logic [YLW-1:0] y_mask;
    logic [YLW-1:0] y_in;

    always_comb begin
        y_mask = ~({YLW{1'b1}} << (BASE_H_LOG2 + int'(exp)));
        y_in   = y_low & y_mask;
    end

    assign swz[1:0] = x_low[1:0];
    assign swz[3:2] = y_in[1:0];
    assign swz[4]   = x_low[2];
    assign swz[5]   = y_in[2];
    assign swz[6]   = x_low[3];

    for (genvar g = 0; g < MEXP; g++) begin : g_yhi
        assign swz[7+g] = y_in[BASE_H_LOG2+g];
    end
endmodule

// File: rtl/bl_tile_base.sv
module bl_tile_base
    import bl_pkg::*;
#(
    parameter int CW = COORD_W,
    parameter int OW = OFF_W,
    parameter int EW = EXP_W
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [CW-1:0] width,
    input  logic [EW-1:0] exp,
    output logic [OW-1:0] base
);
    localparam int WX_W = CW + 1;

    logic [WX_W-1:0] w_round;
    logic [OW-1:0]   tiles_row;
    logic [OW-1:0]   tile_x;
    logic [OW-1:0]   tile_y;
    logic [OW-1:0]   tile_idx;

    always_comb begin
        w_round   = {1'b0, width} + WX_W'((1 << TILE_W_LOG2) - 1);
        tiles_row = OW'(w_round >> TILE_W_LOG2);
        tile_x    = OW'(x >> TILE_W_LOG2);
        tile_y    = OW'(y >> (BASE_H_LOG2 + int'(exp)));
        tile_idx  = tile_y * tiles_row + tile_x;
        base      = tile_idx << (GOB_LOG2 + BASE_H_LOG2 + int'(exp));
    end
endmodule

// File: rtl/bl_linear.sv
module bl_linear
    import bl_pkg::*;
#(
    parameter int CW = COORD_W,
    parameter int PW = PITCH_W,
    parameter int BW = BPP_W,
    parameter int OW = OFF_W
) (
    input  logic [CW-1:0] x,
    input  logic [CW-1:0] y,
    input  logic [PW-1:0] pitch,
    input  logic [BW-1:0] bpp,
    output logic [OW-1:0] offset
);
    always_comb begin
        offset = OW'(y) * OW'(pitch) + OW'(x) * OW'(bpp);
    end
endmodule

// File: rtl/bl_req_check.sv
module bl_req_check
    import bl_pkg::*;
(
    input  req_t   req,
    output fault_e fault
);
    always_comb begin
        if (req.unsupp)
            fault = FLT_FORMAT;
        else if (int'(req.exp) > MAX_EXP)
            fault = FLT_EXPONENT;
        else if (is_tiled(req.exp) && req.bpp != BPP_W'(1 << PIX_LOG2))
            fault = FLT_DEPTH;
        else if (req.x >= req.width || req.y >= req.height)
            fault = FLT_RANGE;
        else
            fault = FLT_NONE;
    end
endmodule

// File: rtl/bl_addr_gen.sv
module bl_addr_gen
    import bl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic [COORD_W-1:0] surf_width,
    input  logic [COORD_W-1:0] surf_height,
    input  logic [EXP_W-1:0]   blk_exp,
    input  logic [BPP_W-1:0]   bytes_pp,
    input  logic [PITCH_W-1:0] lin_pitch,
    input  logic               fmt_unsupp,
    output logic               rsp_valid,
    input  logic               rsp_ready,
    output logic [OFF_W-1:0]   rsp_offset,
    output logic               rsp_err
);
    req_t             req;
    fault_e           fault;
    logic [OFF_W-1:0] tile_base;
    logic [SWZ_W-1:0] swz;
    logic [OFF_W-1:0] lin_off;
    rsp_t             rsp_nxt;
    rsp_t             rsp_q;
    logic             valid_q;
    logic             accept;

    always_comb begin
        req.x      = req_x;
        req.y      = req_y;
        req.width  = surf_width;
        req.height = surf_height;
        req.exp    = blk_exp;
        req.bpp    = bytes_pp;
        req.pitch  = lin_pitch;
        req.unsupp = fmt_unsupp;
    end

    bl_req_check u_check (
        .req   (req),
        .fault (fault)
    );

    bl_tile_base u_base (
        .x     (req.x),
        .y     (req.y),
        .width (req.width),
        .exp   (req.exp),
        .base  (tile_base)
    );

    bl_swizzle u_swz (
        .x_low (req.x[3:0]),
        .y_low (req.y[YL_W-1:0]),
        .exp   (req.exp),
        .swz   (swz)
    );

    bl_linear u_lin (
        .x      (req.x),
        .y      (req.y),
        .pitch  (req.pitch),
        .bpp    (req.bpp),
        .offset (lin_off)
    );

    always_comb begin
        rsp_nxt.err = (fault != FLT_NONE);
        if (rsp_nxt.err)
            rsp_nxt.offset = '0;
        else if (is_tiled(req.exp))
            rsp_nxt.offset = tile_base + (OFF_W'(swz) << PIX_LOG2);
        else
            rsp_nxt.offset = lin_off;
    end

    assign req_ready = !valid_q || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            rsp_q   <= '0;
        end else if (accept) begin
            valid_q <= 1'b1;
            rsp_q   <= rsp_nxt;
        end else if (rsp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign rsp_valid  = valid_q;
    assign rsp_offset = rsp_q.offset;
    assign rsp_err    = rsp_q.err;
endmodule

// File: rtl/bl_addr_gen_chk.sv
module bl_addr_gen_chk
    import bl_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic               req_ready,
    input logic [EXP_W-1:0]   blk_exp,
    input logic [BPP_W-1:0]   bytes_pp,
    input logic               fmt_unsupp,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [OFF_W-1:0]   rsp_offset,
    input logic               rsp_err
);
    logic take;
    assign take = req_valid && req_ready;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (rst)
        take |=> rsp_valid);                                            // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_offset) && $stable(rsp_err))); // R10
    AST_NO_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |-> !req_ready);                      // R10
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> req_ready);                                      // R10
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_offset == '0));                 // R7
    AST_FMT_REJECT: assert property (@(posedge clk) disable iff (rst)
        (take && fmt_unsupp) |=> rsp_err);                              // R6
    AST_EXP_REJECT: assert property (@(posedge clk) disable iff (rst)
        (take && int'(blk_exp) > MAX_EXP) |=> rsp_err);                 // R8
    AST_DEPTH_REJECT: assert property (@(posedge clk) disable iff (rst)
        (take && blk_exp != '0 && bytes_pp != 3'd4) |=> rsp_err);       // R5
endmodule

bind bl_addr_gen bl_addr_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .blk_exp    (blk_exp),
    .bytes_pp   (bytes_pp),
    .fmt_unsupp (fmt_unsupp),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_offset (rsp_offset),
    .rsp_err    (rsp_err)
);

// File: tb/bl_addr_gen_bench.sv
`timescale 1ns/1ps
module bl_addr_gen_bench;
    import bl_pkg::*;

    typedef struct packed {
        logic [15:0] x;
        logic [15:0] y;
        logic [15:0] w;
        logic [15:0] h;
        logic [3:0]  e;
        logic [2:0]  bpp;
        logic [17:0] pitch;
        logic        unsupp;
        logic [31:0] off;
        logic        err;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{16'd10,   16'd2,    16'd1920, 16'd1080, 4'd0, 3'd4, 18'd7680, 1'b0, 32'd15400,   1'b0, 8'd1},  // R1
        '{16'd0,    16'd0,    16'd1920, 16'd1080, 4'd1, 3'd4, 18'd0,    1'b0, 32'd0,       1'b0, 8'd2},  // R2
        '{16'd5,    16'd3,    16'd1920, 16'd1080, 4'd1, 3'd4, 18'd0,    1'b0, 32'd116,     1'b0, 8'd3},  // R3
        '{16'd17,   16'd20,   16'd1920, 16'd1080, 4'd1, 3'd4, 18'd0,    1'b0, 32'd124036,  1'b0, 8'd2},  // R2
        '{16'd15,   16'd31,   16'd1920, 16'd1080, 4'd2, 3'd4, 18'd0,    1'b0, 32'd2044,    1'b0, 8'd3},  // R3
        '{16'd1919, 16'd1079, 16'd1920, 16'd1080, 4'd5, 3'd4, 18'd0,    1'b0, 32'd9817596, 1'b0, 8'd4},  // R4
        '{16'd99,   16'd40,   16'd100,  16'd50,   4'd1, 3'd4, 18'd0,    1'b0, 32'd21004,   1'b0, 8'd2},  // R2 round up
        '{16'd1919, 16'd1079, 16'd1920, 16'd1080, 4'd0, 3'd2, 18'd3840, 1'b0, 32'd4147198, 1'b0, 8'd1},  // R1
        '{16'd5,    16'd3,    16'd1920, 16'd1080, 4'd1, 3'd2, 18'd0,    1'b0, 32'd0,       1'b1, 8'd5},  // R5
        '{16'd5,    16'd3,    16'd1920, 16'd1080, 4'd1, 3'd4, 18'd0,    1'b1, 32'd0,       1'b1, 8'd6},  // R6
        '{16'd1920, 16'd0,    16'd1920, 16'd1080, 4'd0, 3'd4, 18'd7680, 1'b0, 32'd0,       1'b1, 8'd7},  // R7
        '{16'd0,    16'd1080, 16'd1920, 16'd1080, 4'd1, 3'd4, 18'd0,    1'b0, 32'd0,       1'b1, 8'd7},  // R7
        '{16'd5,    16'd3,    16'd1920, 16'd1080, 4'd6, 3'd4, 18'd0,    1'b0, 32'd0,       1'b1, 8'd8}   // R8
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [15:0] req_x, req_y, surf_width, surf_height;
    logic [3:0]  blk_exp;
    logic [2:0]  bytes_pp;
    logic [17:0] lin_pitch;
    logic        fmt_unsupp;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [31:0] rsp_offset;
    logic        rsp_err;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bl_addr_gen u_bl_addr_gen (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .surf_width(surf_width), .surf_height(surf_height),
        .blk_exp(blk_exp), .bytes_pp(bytes_pp), .lin_pitch(lin_pitch), .fmt_unsupp(fmt_unsupp),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_offset(rsp_offset), .rsp_err(rsp_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp_v);
        end
    endtask

    task automatic drive(input vec_t v);
        req_x = v.x; req_y = v.y; surf_width = v.w; surf_height = v.h;
        blk_exp = v.e; bytes_pp = v.bpp; lin_pitch = v.pitch; fmt_unsupp = v.unsupp;
        req_valid = 1'b1;
    endtask

    task automatic check_rsp(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.rq);
        check({tag, " offset"}, rsp_offset, v.off);
        check({tag, " err"}, 32'(rsp_err), 32'(v.err));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; rsp_ready = 1'b1; req_valid = 1'b0;
        drive(TBL[0]); req_valid = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R11 valid after reset", 32'(rsp_valid), 32'd0);
        check("R11 ready after reset", 32'(req_ready), 32'd1);
        rst = 1'b0;

        // Vector table: result due one edge after acceptance (R9)
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(posedge clk);
            @(negedge clk);
            req_valid = 1'b0;
            check("R9 valid", 32'(rsp_valid), 32'd1);
            check_rsp(TBL[i]);
        end
        @(negedge clk);
        check("R9 idle drop", 32'(rsp_valid), 32'd0);

        // Backpressure: hold result, stall next request (R10)
        rsp_ready = 1'b0;
        drive(TBL[2]);
        @(posedge clk);
        @(negedge clk);
        drive(TBL[3]);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 held valid", 32'(rsp_valid), 32'd1);
        check("R10 ready low", 32'(req_ready), 32'd0);
        check("R10 held offset", rsp_offset, 32'd116);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R10 queued valid", 32'(rsp_valid), 32'd1);
        check("R10 queued offset", rsp_offset, 32'd124036);

        // Reset with a pending result (R11)
        rsp_ready = 1'b0;
        drive(TBL[4]);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R11 valid cleared", 32'(rsp_valid), 32'd0);
        check("R11 ready restored", 32'(req_ready), 32'd1);
        rst = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule